// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase samples into a frequency error word. Each accepted phase sample has a copy of an earlier sample, taken a programmable number of samples back, subtracted from it. The result is a discrete estimate of dθ/dt. The subtraction uses two's complement arithmetic that wraps naturally, so a step across the ±π boundary gives the short difference rather than a near-full-scale one. The look-back distance is 2^K samples and sets the discriminator gain.

A signed 5-bit offset is then added, with wraparound, into the five most significant bits of the difference. A left shift of 0 to 4 places follows, which discards the bits shifted out at the top and fills the bottom with zeros. This produces the frequency error word for a carrier tracking loop. When frequency-aided acquisition is used with PSK signals, software programs both the offset and the shift to zero.

The phase samples are written into a small circular history buffer. After reset, and after every change of the look-back distance, the block emits nothing until the buffer holds enough new samples to form a true difference.

Top module: `freq_discriminator`

## Requirements
- R1: After reset, freq_vld is 0, freq_err is 0 and cfg_err is 0. The look-back distance is 1 sample (K=0), and the offset and the shift are both 0.
- R2: Suppose phase_vld is high in a cycle with dly_wr low, and the block is primed (see R5). Then, one clock later, freq_vld is 1 and freq_err = ((phase_in − P + (off << (PW−5))) << sh) mod 2^PW, where P is the sample accepted 2^K accepted samples earlier.
- R3: The phase difference wraps modulo 2^PW. For example, 16'h8100 after 16'h7F00 with K=0, offset 0 and shift 0 gives 16'h0200.
- R4: The K code is written through dly_code when dly_wr is high. Codes 0 to 4 select a look-back of 1, 2, 4, 8 or 16 accepted samples.
- R5: After reset, and after every delay write, the first 2^K accepted samples produce no output. Each accepted sample after that produces one output.
- R6: A sample presented in the same cycle as a delay write is discarded. It produces no output and does not count toward the priming of R5.
- R7: On a write with cfg_wr high, cfg_word[7:3] is a two's complement offset (10000 = −16, 01111 = +15). It is added modulo 2^PW at bit weight 2^(PW−5) of the difference.
- R8: cfg_word[2:0] is the shift code. Codes 0 to 4 give a left shift of that many places. Bits shifted past the MSB are lost, and the LSBs are filled with zeros.
- R9: K codes 5 to 7 act as K=4, and shift codes 5 to 7 act as a shift of 4. Either kind of write sets cfg_err, which stays at 1 until reset.
- R10: A register write affects only samples accepted in later cycles. A sample in the same cycle as a cfg_wr uses the previous offset and shift.
- R11: When no sample is accepted, freq_vld is 0 one clock later and freq_err holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_vld | input | 1 | Phase sample strobe |
| phase_in | input | PW | Phase sample, full scale = 2π |
| dly_wr | input | 1 | Write strobe for the look-back code |
| dly_code | input | 3 | Look-back code K |
| cfg_wr | input | 1 | Write strobe for offset and shift |
| cfg_word | input | 8 | [7:3] offset, [2:0] shift code |
| freq_vld | output | 1 | Frequency error valid |
| freq_err | output | PW | Frequency error word |
| cfg_err | output | 1 | Sticky flag for an invalid code |

## Verification
Properties in the design check the following on every cycle:
- every valid output follows an accepted sample;
- a delay write suppresses the next output;
- the output word holds its value while no output is valid;
- cfg_err is sticky, and it rises only after a write that carried an invalid code.

The arithmetic itself can only be shown by the bench's scenarios, where a queue-based model is compared with the output on every clock. Those scenarios cover the values produced by each look-back distance, the length of the priming window, the wrap across ±π, the extreme offsets, and the loss of MSBs under shifting.

// File: rtl/freq_discriminator.sv
module freq_discriminator #(
  parameter int PW    = 16,
  parameter int K_MAX = 4,
  parameter int SH_MAX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_vld,
  input  logic [PW-1:0] phase_in,
  input  logic          dly_wr,
  input  logic [2:0]    dly_code,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_word,
  output logic          freq_vld,
  output logic [PW-1:0] freq_err,
  output logic          cfg_err
);
  localparam int DEPTH = 1 << K_MAX;
  localparam int AW    = K_MAX;
  localparam int FW    = K_MAX + 1;
  localparam int OFS_W = 5;

  logic [PW-1:0]    hist [DEPTH];
  logic [AW-1:0]    wp;
  logic [FW-1:0]    fill_q;
  logic [2:0]       k_q;
  logic [2:0]       sh_q;
  logic [OFS_W-1:0] off_q;

  wire          take    = phase_vld && !dly_wr;
  wire [FW-1:0] dly_len = FW'(1) << k_q;
  wire [AW-1:0] rp      = wp - dly_len[AW-1:0];
  wire          primed  = fill_q >= dly_len;

  wire          k_bad  = dly_code > 3'(K_MAX);
  wire          sh_bad = cfg_word[2:0] > 3'(SH_MAX);
  wire [2:0]    k_new  = k_bad ? 3'(K_MAX) : dly_code;
  wire [2:0]    sh_new = sh_bad ? 3'(SH_MAX) : cfg_word[2:0];

  wire [PW-1:0] diff   = phase_in - hist[rp];
  wire [PW-1:0] ofs_w  = {off_q, {(PW-OFS_W){1'b0}}};
  wire [PW-1:0] biased = diff + ofs_w;
  wire [PW-1:0] result = biased << sh_q;

  always_ff @(posedge clk)
    if (take) hist[wp] <= phase_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      fill_q <= '0;
    end else if (dly_wr) begin
      fill_q <= '0;
    end else if (phase_vld) begin
      wp <= wp + 1'b1;
      if (fill_q < FW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q     <= '0;
      sh_q    <= '0;
      off_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (dly_wr) k_q <= k_new;
      if (cfg_wr) begin
        sh_q  <= sh_new;
        off_q <= cfg_word[7:3];
      end
      if ((dly_wr && k_bad) || (cfg_wr && sh_bad)) cfg_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_vld <= 1'b0;
      freq_err <= '0;
    end else begin
      freq_vld <= take && primed;
      if (take && primed) freq_err <= result;
    end
  end

  a_r11_vld_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    freq_vld |-> $past(phase_vld));

  a_r6_dly_wr_blocks_output: assert property (@(posedge clk) disable iff (!rst_n)
    dly_wr |=> !freq_vld);

  a_r11_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_vld |-> $stable(freq_err));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past((cfg_wr && cfg_word[2:0] > 3'(SH_MAX)) ||
                             (dly_wr && dly_code > 3'(K_MAX))));

  a_r5_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dly_wr) |-> fill_q == '0);
endmodule

// File: tb/freq_discriminator_tb.sv
`timescale 1ns/1ps
module freq_discriminator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase_vld;
  logic [15:0] phase_in;
  logic        dly_wr;
  logic [2:0]  dly_code;
  logic        cfg_wr;
  logic [7:0]  cfg_word;
  logic        freq_vld;
  logic [15:0] freq_err;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  logic [15:0] hist[$];
  int          fill, mk, msh;
  logic [4:0]  moff;
  bit          merr;
  bit          exp_vld;
  logic [15:0] exp_err;

  always #2 clk = ~clk;

  freq_discriminator u_dut (
    .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase_in(phase_in),
    .dly_wr(dly_wr), .dly_code(dly_code), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .freq_vld(freq_vld), .freq_err(freq_err), .cfg_err(cfg_err));

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R11: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0; phase_vld = 0; phase_in = 0; dly_wr = 0; dly_code = 0;
    cfg_wr = 0; cfg_word = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    hist.delete(); fill = 0; mk = 0; msh = 0; moff = 0; merr = 0;
    exp_vld = 0; exp_err = 0;
    checks++;
    if (freq_vld !== 1'b0 || freq_err !== 16'h0 || cfg_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual vld=%b err=%h cerr=%b expected 0 0000 0",
               freq_vld, freq_err, cfg_err);
    end
  endtask

  task automatic step(bit pv, logic [15:0] ph, bit cw, logic [7:0] cd,
                      bit dw, logic [2:0] dk, string req);
    int d;
    logic [15:0] diff, sum;
    phase_vld = pv; phase_in = ph; cfg_wr = cw; cfg_word = cd;
    dly_wr = dw; dly_code = dk;
    exp_vld = 0;
    if (pv && !dw) begin
      d = 1 << mk;
      if (fill >= d) begin
        diff = ph - hist[hist.size() - d];
        sum = diff + {moff, 11'b0};
        exp_err = sum << msh;
        exp_vld = 1;
      end
      hist.push_back(ph);
      if (hist.size() > 16) void'(hist.pop_front());
      if (fill < 16) fill++;
    end
    if (dw) begin
      mk = (dk > 4) ? 4 : int'(dk);
      if (dk > 4) merr = 1;
      fill = 0;
      hist.delete();
    end
    if (cw) begin
      moff = cd[7:3];
      msh = (cd[2:0] > 4) ? 4 : int'(cd[2:0]);
      if (cd[2:0] > 4) merr = 1;
    end
    @(posedge clk);
    @(negedge clk);
    phase_vld = 0; cfg_wr = 0; dly_wr = 0;
    checks++;
    if (freq_vld !== exp_vld || freq_err !== exp_err || cfg_err !== merr) begin
      errors++;
      $display("FAIL %s: actual vld=%b err=%h cerr=%b expected vld=%b err=%h cerr=%b",
               req, freq_vld, freq_err, cfg_err, exp_vld, exp_err, merr);
    end
  endtask

  task automatic smp(logic [15:0] ph, string req);
    step(1, ph, 0, 8'h0, 0, 3'd0, req);
  endtask

  task automatic idle(string req);
    step(0, 16'h0, 0, 8'h0, 0, 3'd0, req);
  endtask

  task automatic wcfg(logic [7:0] cd, string req);
    step(0, 16'h0, 1, cd, 0, 3'd0, req);
  endtask

  task automatic wdly(logic [2:0] k, string req);
    step(0, 16'h0, 0, 8'h0, 1, k, req);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 20; i++) smp(16'($urandom), "R2");
    smp(16'h7F00, "R3"); smp(16'h8100, "R3");
    smp(16'h8000, "R3"); smp(16'h7FFF, "R3");
    for (int k = 1; k <= 4; k++) begin
      wdly(3'(k), "R4");
      for (int i = 0; i < (1 << k) + 6; i++) smp(16'($urandom), "R5");
    end
    for (int i = 0; i < 40; i++) step($urandom_range(0, 1), 16'($urandom), 0, 8'h0, 0, 3'd0, "R11");
    wdly(3'd1, "R4");
    wcfg({5'b10000, 3'd0}, "R7");
    for (int i = 0; i < 8; i++) smp(16'($urandom), "R7");
    wcfg({5'b01111, 3'd0}, "R7");
    for (int i = 0; i < 8; i++) smp(16'($urandom), "R7");
    for (int s = 0; s <= 4; s++) begin
      wcfg({5'd3, 3'(s)}, "R8");
      for (int i = 0; i < 8; i++) smp(16'($urandom), "R8");
    end
    step(1, 16'h1234, 1, {5'b11101, 3'd2}, 0, 3'd0, "R10");
    for (int i = 0; i < 4; i++) smp(16'($urandom), "R10");
    step(1, 16'h4444, 0, 8'h0, 1, 3'd2, "R6");
    for (int i = 0; i < 8; i++) smp(16'($urandom), "R6");
    wdly(3'd6, "R9");
    for (int i = 0; i < 22; i++) smp(16'($urandom), "R9");
    do_reset();
    for (int i = 0; i < 4; i++) smp(16'($urandom), "R1");
    wcfg({5'd1, 3'd7}, "R9");
    for (int i = 0; i < 8; i++) smp(16'($urandom), "R9");
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 19) == 0)
        step($urandom_range(0, 1), 16'($urandom), 1, 8'($urandom), 0, 3'd0, "R2");
      else if ($urandom_range(0, 29) == 0)
        step($urandom_range(0, 1), 16'($urandom), 0, 8'h0, 1, 3'($urandom), "R5");
      else
        step($urandom_range(0, 3) != 0, 16'($urandom), 0, 8'h0, 0, 3'd0, "R2");
    end
    idle("R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule